// File: doc/BRIEF.md
# Read-Only Four-Way Instruction Cache with Age-Counter Replacement

This block sits between a processor fetch port and a memory that returns one 32-bit word per handshake. A request carries a 32-bit byte address. The cache splits that address into a tag, a set index and a byte offset, and it compares the tags of all ways of the selected set in the same cycle. On a hit it returns the requested word in that cycle. On a miss it stalls the requester, chooses a way, and refills the whole line from memory one word at a time. It returns the word once the fixed miss penalty has passed and the refill is complete.

Each way carries a valid bit and a small saturating age counter. A higher age marks a way that has gone unused for longer. The way with the highest age is the one replaced when the set is full. The processor never writes through this block, so the block has no dirty state and no write-back path.

Top module: `ro_cache`

## Requirements
- R1: The request address is split as byte offset = bits [4:0], set index = bits [10:5] and tag = bits [31:11]. Addresses that share a set but differ in tag occupy separate lines. Addresses that share a tag but differ in set occupy separate lines. Addresses that differ only in bits [4:0] hit the same line.
- R2: A request whose set holds a valid way with a matching tag is a hit. On a hit `cpu_ready` is high in the same cycle as `cpu_req`, and no memory request is issued.
- R3: The returned word is little-endian. The byte at line offset n lands in bits [7:0] and bytes n+1..n+3 land in the higher bytes in order. For the aligned offsets used here, the word at line offset 4i equals the i-th memory word of the line.
- R4: On a miss, `cpu_ready` stays low and rises exactly 50 cycles after the cycle in which the miss was seen, provided the refill has finished by then. It never rises earlier.
- R5: A refill issues 8 word requests at consecutive addresses starting at the line base (the request address with bits [4:0] cleared). The requests come in ascending order, and each address is held stable until the word is accepted.
- R6: On a miss the lowest-numbered invalid way is filled. That way's age becomes 0, and each valid way whose age is below the filled way's former age gains one.
- R7: On a hit every other way whose age is below the hit way's age gains one, and the hit way's age becomes 0. Ages are 2 bits wide and saturate at 3.
- R8: On a miss in a full set, every age first gains one (saturating). The way with the largest age is then replaced, with ties going to the highest index, and its age becomes 0.
- R9: Reset invalidates every line and clears every age. While in reset and after it, `cpu_ready` and `mem_req` are low until a request arrives, and the first access to any address misses.
- R10: When memory is slow, the response waits for the refill. `cpu_ready` rises two cycles after the last refill word is accepted if that is later than the 50-cycle penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Fetch request, held with its address until `cpu_ready` |
| cpu_addr | input | 32 | Byte address of the fetch, bits [1:0] zero |
| cpu_ready | output | 1 | Request served this cycle, `cpu_rdata` valid |
| cpu_rdata | output | 32 | Fetched word |
| mem_req | output | 1 | Refill word request |
| mem_addr | output | 32 | Word-aligned refill address |
| mem_valid | input | 1 | Memory accepts the request and presents `mem_rdata` this cycle |
| mem_rdata | input | 32 | Refill word |

## Verification
A behavioural reference cache in the bench runs alongside the design and predicts `cpu_ready` every cycle, the data on every response, and the address of every refill word. Several kinds of stimulus are used:
- A cold sweep over all eight words of one line separates miss timing from hit timing and confirms the word ordering.
- Same-set/other-tag accesses, set against same-tag/other-set accesses, expose any error in the address split.
- Filling a set, then re-touching its ways in chosen orders, and then missing into the full set makes the replacement choice visible as later hits or misses. This covers the all-equal-age tie as well.
- Slow-memory refills and a long pseudo-random mix over two sets and six tags show whether the stall length follows the penalty or the refill, and shake out age-update interactions.

// File: rtl/rc_pkg.sv
package rc_pkg;
   typedef enum logic [0:0] {
      ST_LOOK = 1'b0,
      ST_FILL = 1'b1
   } rc_state_e;

   localparam int RC_WORD_W     = 32;
   localparam int RC_WORD_BYTES = RC_WORD_W / 8;
endpackage

// File: rtl/rc_tag_match.sv
module rc_tag_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 21,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS*TAG_W-1:0] tags_i,
   input  logic [WAYS-1:0]       valid_i,
   input  logic [TAG_W-1:0]      tag_i,
   output logic [WAYS-1:0]       hit_vec_o,
   output logic                  hit_o,
   output logic [WAY_W-1:0]      hit_way_o
);
   // one comparator per way
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec_o[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
   end

   assign hit_o = |hit_vec_o;

   always_comb begin
      hit_way_o = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hit_vec_o[i]) hit_way_o = WAY_W'(i);
      end
   end
endmodule

// File: rtl/rc_age_policy.sv
module rc_age_policy #(
   parameter int WAYS  = 4,
   parameter int AGE_W = 2,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS*AGE_W-1:0] ages_i,
   input  logic [WAYS-1:0]       valid_i,
   input  logic                  hit_i,
   input  logic [WAY_W-1:0]      hit_way_i,
   output logic [WAYS*AGE_W-1:0] ages_o,
   output logic [WAY_W-1:0]      victim_o
);
   localparam logic [AGE_W-1:0] AGE_TOP = '1;

   logic [AGE_W-1:0] cur_a  [WAYS];
   logic [AGE_W-1:0] bump_a [WAYS];
   logic [AGE_W-1:0] nxt_a  [WAYS];
   logic             free_found;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] old_way;
   logic [AGE_W-1:0] best_age;
   logic [AGE_W-1:0] ref_age;

   for (genvar w = 0; w < WAYS; w++) begin : g_unpack
      assign cur_a[w]  = ages_i[w*AGE_W +: AGE_W];
      assign bump_a[w] = (cur_a[w] == AGE_TOP) ? cur_a[w] : cur_a[w] + 1'b1;
      assign ages_o[w*AGE_W +: AGE_W] = nxt_a[w];
   end

   // lowest invalid way
   always_comb begin
      free_found = 1'b0;
      free_way   = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (!valid_i[i] && !free_found) begin
            free_found = 1'b1;
            free_way   = WAY_W'(i);
         end
      end
   end

   // oldest way after aging, ties to the higher index
   always_comb begin
      old_way  = '0;
      best_age = bump_a[0];
      for (int i = 1; i < WAYS; i++) begin
         if (bump_a[i] >= best_age) begin
            best_age = bump_a[i];
            old_way  = WAY_W'(i);
         end
      end
   end

   assign victim_o = free_found ? free_way : old_way;

   always_comb begin
      ref_age = hit_i ? cur_a[hit_way_i] : cur_a[free_way];
      for (int i = 0; i < WAYS; i++) begin
         if (hit_i) begin
            if (WAY_W'(i) == hit_way_i)  nxt_a[i] = '0;
            else if (cur_a[i] < ref_age) nxt_a[i] = bump_a[i];
            else                         nxt_a[i] = cur_a[i];
         end else if (free_found) begin
            if (WAY_W'(i) == free_way)                nxt_a[i] = '0;
            else if (valid_i[i] && cur_a[i] < ref_age) nxt_a[i] = bump_a[i];
            else                                       nxt_a[i] = cur_a[i];
         end else begin
            nxt_a[i] = (WAY_W'(i) == old_way) ? '0 : bump_a[i];
         end
      end
   end
endmodule

// File: rtl/ro_cache.sv
module ro_cache #(
   parameter int ADDR_W       = 32,
   parameter int SETS         = 64,
   parameter int WAYS         = 4,
   parameter int LINE_BYTES   = 32,
   parameter int AGE_W        = 2,
   parameter int MISS_PENALTY = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic [31:0]       cpu_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [31:0]       mem_rdata
);
   import rc_pkg::*;

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int WPL    = LINE_BYTES / RC_WORD_BYTES;
   localparam int WIDX_W = $clog2(WPL);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int PEN_W  = $clog2(MISS_PENALTY + 1);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int NLINES = SETS * WAYS;
   localparam int NWORDS = NLINES * WPL;

   // elaboration-time parameter checks
   if ((SETS & (SETS - 1)) != 0 || SETS < 2) begin : g_bad_sets
      $error("ro_cache: SETS must be a power of two of at least 2");
   end
   if ((WAYS & (WAYS - 1)) != 0 || WAYS < 2) begin : g_bad_ways
      $error("ro_cache: WAYS must be a power of two of at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 8) begin : g_bad_line
      $error("ro_cache: LINE_BYTES must be a power of two of at least 8");
   end
   if (MISS_PENALTY < 2) begin : g_bad_pen
      $error("ro_cache: MISS_PENALTY must be at least 2");
   end
   if (AGE_W < 1 || TAG_W < 1) begin : g_bad_fields
      $error("ro_cache: address too narrow or age width zero");
   end

   // storage
   logic [TAG_W-1:0]      tag_q  [NLINES];
   logic [WAYS-1:0]       valid_q[SETS];
   logic [WAYS*AGE_W-1:0] age_q  [SETS];
   logic [31:0]           data_q [NWORDS];

   // request decode
   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_set;
   logic [WIDX_W-1:0] req_word;
   logic              addr_lsb_unused;

   assign req_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
   assign req_set         = cpu_addr[OFF_W +: IDX_W];
   assign req_word        = cpu_addr[2 +: WIDX_W];
   assign addr_lsb_unused = ^cpu_addr[1:0];

   logic [WAYS*TAG_W-1:0] set_tags;
   logic [WAYS-1:0]       set_valid;
   logic [WAYS*AGE_W-1:0] set_age;

   for (genvar w = 0; w < WAYS; w++) begin : g_tag_rd
      assign set_tags[w*TAG_W +: TAG_W] = tag_q[{req_set, WAY_W'(w)}];
   end
   assign set_valid = valid_q[req_set];
   assign set_age   = age_q[req_set];

   logic [WAYS-1:0]       hit_vec;
   logic                  hit;
   logic [WAY_W-1:0]      hit_way;
   logic [WAYS*AGE_W-1:0] next_age;
   logic [WAY_W-1:0]      victim;

   rc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
      .tags_i   (set_tags),
      .valid_i  (set_valid),
      .tag_i    (req_tag),
      .hit_vec_o(hit_vec),
      .hit_o    (hit),
      .hit_way_o(hit_way)
   );

   rc_age_policy #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_age (
      .ages_i   (set_age),
      .valid_i  (set_valid),
      .hit_i    (hit),
      .hit_way_i(hit_way),
      .ages_o   (next_age),
      .victim_o (victim)
   );

   // control
   rc_state_e         state;
   logic [IDX_W-1:0]  fill_set;
   logic [WAY_W-1:0]  fill_way;
   logic [LINE_W-1:0] fill_line;
   logic [WIDX_W-1:0] widx;
   logic              filled;
   logic [PEN_W-1:0]  pen;
   logic              look, hit_go, miss_go, word_in;

   assign look    = (state == ST_LOOK) && cpu_req;
   assign hit_go  = look && hit;
   assign miss_go = look && !hit;
   assign word_in = mem_req && mem_valid;

   assign cpu_ready = hit_go;
   assign cpu_rdata = hit_go ? data_q[{req_set, hit_way, req_word}] : '0;
   assign mem_req   = (state == ST_FILL) && !filled;
   assign mem_addr  = {fill_line, widx, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_LOOK;
         fill_set  <= '0;
         fill_way  <= '0;
         fill_line <= '0;
         widx      <= '0;
         filled    <= 1'b0;
         pen       <= '0;
      end else begin
         case (state)
            ST_LOOK: begin
               if (miss_go) begin
                  state     <= ST_FILL;
                  fill_set  <= req_set;
                  fill_way  <= victim;
                  fill_line <= cpu_addr[ADDR_W-1:OFF_W];
                  widx      <= '0;
                  filled    <= 1'b0;
                  pen       <= '0;
               end
            end
            ST_FILL: begin
               if (pen != PEN_W'(MISS_PENALTY)) pen <= pen + 1'b1;
               if (word_in) begin
                  widx <= widx + 1'b1;
                  if (widx == WIDX_W'(WPL - 1)) filled <= 1'b1;
               end
               if (filled && pen >= PEN_W'(MISS_PENALTY - 2)) state <= ST_LOOK;
            end
            default: state <= ST_LOOK;
         endcase
      end
   end

   // valid bits and ages
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            age_q[s]   <= '0;
         end
      end else begin
         if (hit_go || miss_go) age_q[req_set] <= next_age;
         if (miss_go)           valid_q[req_set][victim] <= 1'b1;
      end
   end

   // tags and line data, no reset needed
   always_ff @(posedge clk) begin
      if (miss_go) tag_q[{req_set, victim}] <= req_tag;
      if (word_in) data_q[{fill_set, fill_way, widx}] <= mem_rdata;
   end
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
   parameter int MISS_PENALTY = 50,
   parameter int ADDR_W       = 32,
   parameter int WAYS         = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cpu_req,
   input logic                     cpu_ready,
   input logic                     mem_req,
   input logic                     mem_valid,
   input logic [ADDR_W-1:0]        mem_addr,
   input logic [WAYS-1:0]          hit_vec,
   input logic [WAYS-1:0]          set_valid,
   input logic [$clog2(WAYS)-1:0]  victim,
   input logic                     miss_go
);
   logic [15:0] stall_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      stall_cnt <= '0;
      else if (cpu_req && !cpu_ready) begin
         if (stall_cnt != 16'hFFFF)    stall_cnt <= stall_cnt + 1'b1;
      end else                         stall_cnt <= '0;
   end

   a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req |-> $onehot0(hit_vec));

   a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   a_r4_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && stall_cnt != 0) |-> (stall_cnt >= 16'(MISS_PENALTY)));

   a_r5_refill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00) && !cpu_ready);

   a_r5_refill_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> mem_req && $stable(mem_addr));

   a_r6_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_go && !(&set_valid)) |-> !set_valid[victim]);
endmodule

bind ro_cache rc_checker #(
   .MISS_PENALTY(MISS_PENALTY),
   .ADDR_W      (ADDR_W),
   .WAYS        (WAYS)
) u_rc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_ready(cpu_ready),
   .mem_req  (mem_req),
   .mem_valid(mem_valid),
   .mem_addr (mem_addr),
   .hit_vec  (hit_vec),
   .set_valid(set_valid),
   .victim   (victim),
   .miss_go  (miss_go)
);

// File: tb/tb_ro_cache.sv
module tb_ro_cache;
   localparam int SETS  = 64;
   localparam int WAYS  = 4;
   localparam int PEN   = 50;
   localparam int AMAX  = 3;
   localparam int LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid;
   logic [31:0] mem_rdata;

   int n_chk = 0;
   int n_bad = 0;
   int mem_lat = 0;
   int lat_cnt = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   ro_cache dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E3779B1) ^ 32'h5A17C3E9 ^ {a[15:0], a[31:16]};
   endfunction

   assign mem_valid = mem_req && (lat_cnt >= mem_lat);
   assign mem_rdata = mem_word(mem_addr);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && !mem_valid) lat_cnt <= lat_cnt + 1;
      else                       lat_cnt <= 0;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc == LIMIT) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, LIMIT);
         summary();
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // reference model
   int m_tag [SETS][WAYS];
   bit m_val [SETS][WAYS];
   int m_age [SETS][WAYS];

   function automatic logic [31:0] mk(input int tag, input int set, input int word);
      logic [31:0] a;
      a = {21'(tag), 6'(set), 3'(word), 2'b00};
      return a;
   endfunction

   // applies one access to the model, returns whether it hits
   function automatic bit model_access(input logic [31:0] a);
      int s, t, w, ref_a, best, best_a;
      s = int'(a[10:5]);
      t = int'(a[31:11]);
      w = -1;
      for (int i = 0; i < WAYS; i++)
         if (m_val[s][i] && m_tag[s][i] == t) w = i;
      if (w >= 0) begin
         ref_a = m_age[s][w];
         for (int i = 0; i < WAYS; i++)
            if (i != w && m_age[s][i] < ref_a) m_age[s][i]++;
         m_age[s][w] = 0;
         return 1'b1;
      end
      for (int i = WAYS - 1; i >= 0; i--)
         if (!m_val[s][i]) w = i;
      if (w >= 0) begin
         ref_a = m_age[s][w];
         for (int i = 0; i < WAYS; i++)
            if (m_val[s][i] && m_age[s][i] < ref_a) m_age[s][i]++;
      end else begin
         best = 0;
         best_a = -1;
         for (int i = 0; i < WAYS; i++) begin
            if (m_age[s][i] < AMAX) m_age[s][i]++;
            if (m_age[s][i] >= best_a) begin
               best_a = m_age[s][i];
               best = i;
            end
         end
         w = best;
      end
      m_tag[s][w] = t;
      m_val[s][w] = 1'b1;
      m_age[s][w] = 0;
      return 1'b0;
   endfunction

   // entered just after a rising edge; leaves just after a rising edge
   task automatic access(input logic [31:0] a, input string req);
      bit hit_exp, exp_rdy;
      int words, tlast;
      logic [31:0] base;
      cpu_req  = 1'b1;
      cpu_addr = a;
      hit_exp  = model_access(a);
      base     = {a[31:5], 5'b0};
      words    = 0;
      tlast    = -100;
      for (int k = 0; ; k++) begin
         @(negedge clk);
         if (hit_exp) exp_rdy = 1'b1;
         else         exp_rdy = (k >= PEN) && (words == 8) && (k >= tlast + 2);
         check(cpu_ready === exp_rdy, req, $sformatf("ready at stall cycle %0d", k),
               32'(cpu_ready), 32'(exp_rdy));
         if (exp_rdy || cpu_ready) begin
            check(cpu_rdata === mem_word(a), "R3", "returned word", cpu_rdata, mem_word(a));
            if (hit_exp)
               check(mem_req === 1'b0, "R2", "memory idle on hit", 32'(mem_req), 32'd0);
            break;
         end
         if (mem_req && mem_valid) begin
            check(mem_addr === base + 32'(4 * words), "R5", "refill address",
                  mem_addr, base + 32'(4 * words));
            words++;
            tlast = k;
         end
         @(posedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
   endtask

   initial begin
      int unsigned r;
      for (int s = 0; s < SETS; s++)
         for (int i = 0; i < WAYS; i++) begin
            m_val[s][i] = 1'b0;
            m_age[s][i] = 0;
            m_tag[s][i] = 0;
         end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(cpu_ready === 1'b0, "R9", "ready in reset", 32'(cpu_ready), 32'd0);
      check(mem_req === 1'b0, "R9", "mem_req in reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      check(cpu_ready === 1'b0, "R9", "ready idle after reset", 32'(cpu_ready), 32'd0);
      check(mem_req === 1'b0, "R9", "mem_req idle after reset", 32'(mem_req), 32'd0);
      @(posedge clk);
      #1;

      // cold miss, then every word of the line
      access(mk(1, 5, 3), "R9");
      for (int w = 0; w < 8; w++) access(mk(1, 5, w), "R2");

      // address split
      access(mk(2, 5, 0), "R1");
      access(mk(1, 6, 0), "R1");
      access(mk(1, 5, 7), "R1");
      access(mk(2, 5, 4), "R1");

      // fill remaining ways
      access(mk(3, 5, 1), "R6");
      access(mk(4, 5, 2), "R6");
      for (int t = 1; t <= 4; t++) access(mk(t, 5, 6), "R2");

      // reorder ages by hits, then evict
      access(mk(2, 5, 0), "R7");
      access(mk(2, 5, 1), "R7");
      access(mk(1, 5, 2), "R7");
      access(mk(7, 5, 0), "R8");
      for (int t = 1; t <= 4; t++) access(mk(t, 5, 3), "R8");

      // equal-age tie in a freshly filled set
      for (int t = 10; t <= 13; t++) access(mk(t, 9, 0), "R6");
      access(mk(14, 9, 0), "R8");
      access(mk(13, 9, 0), "R8");
      access(mk(10, 9, 5), "R8");
      access(mk(14, 9, 5), "R8");

      // slow memory
      mem_lat = 8;
      access(mk(20, 12, 2), "R10");
      mem_lat = 2;
      access(mk(21, 12, 5), "R10");
      mem_lat = 0;
      access(mk(20, 12, 7), "R10");

      // pseudo-random mix
      r = 32'h1234_5678;
      for (int n = 0; n < 400; n++) begin
         r = r * 32'd1103515245 + 32'd12345;
         if (n % 37 == 5) mem_lat = int'(r[27:26]) * 4;
         else if (n % 37 == 6) mem_lat = 0;
         access(mk(1 + int'(r[18:16]) % 6, 30 + int'(r[20]), int'(r[23:21])), "R7");
      end

      summary();
   end
endmodule